// File: doc/BRIEF.md
# Motor Fault Diagnosis Sequencer

This block decides when a three-phase bridge motor driver may run, and it works out what failed when a fault appears. While the bridge is off it watches per-phase comparator flags that show whether each motor terminal sits above a battery-level threshold or below a ground-level threshold. With the motor connected and healthy, all three terminals sit between the two thresholds. A start request turns the bridge on only when this off-state check is clean. While the bridge runs, the block watches per-phase drain-source flags on the high and low switches and one shared shunt comparator. The first on-state fault turns the bridge off and restarts the off-state monitor. After a settling time, the block combines the stored on-state flags with the fresh off-state pattern to name the fault.

Results go into a 23-bit latched failure register that appears on a plain output. A system controller reads that output and then issues a clear command. The bridge cannot start again until the register is empty. Each comparator input passes through a two-flop synchronizer and a glitch filter before the block uses it. The shunt comparator threshold select follows the PWM phase. It picks the short-to-battery level while the switches conduct and the weak-short level while the current freewheels.

Top module: `mfd_seq`

## Requirements
- R1: Every comparator input is synchronized by two flops and then filtered. A change shows up inside the block FILT_LEN+2 clock edges after it reaches the pin, and a pulse shorter than FILT_LEN cycles is ignored. With the bridge off and the register empty, an off-state failure that appears at the pins is latched one edge after the filter output changes, which is FILT_LEN+3 edges after the change at the pins.
- R2: After reset, bridge_en_o is low, off_mon_en_o is high and fault_o is zero. A start request is accepted only when all of the following hold: the off monitor has run for SETTLE_LEN cycles, the register is empty, and no off-state failure is present. The bridge then turns on one edge after the request, on_mon_en_o goes high and off_mon_en_o goes low.
- R3: While the bridge is off and the register is empty, any off-state failure is latched, and start requests are ignored from then on.
- R4: Off-state inputs use bit 0 for phase U, bit 1 for V and bit 2 for W. The patterns are decoded as follows, with no on-state flags involved:
  - battery 111 with ground 000 sets fault bit 15;
  - battery 000 with ground 111 sets fault bit 16;
  - battery 110 with ground 001 sets bit 6 (open load on U);
  - battery 010 with ground 101 sets bit 7 (open load on V);
  - battery 011 with ground 100 sets bit 8 (open load on W);
  - any other nonzero pattern sets bit 21.
- R5: The bridge turns off FILT_LEN+3 edges after an on-state flag reaches the pins, and the off monitor restarts on the same edge. The combined diagnosis is latched SETTLE_LEN+1 edges after the bridge turns off.
- R6: If a single on-state battery flag meets the all-battery off pattern, bits 2:0 record the phase. If a single on-state ground flag meets the all-ground off pattern, bits 5:3 record the phase.
- R7: If a single on-state flag of either kind meets a clean off-state pattern, a load short is recorded at that phase in bits 11:9.
- R8: If one on-state battery flag and one ground flag on two different phases meet a clean off-state pattern, a phase-to-phase short is recorded in either order: bit 12 for U-V, bit 13 for V-W, bit 14 for W-U.
- R9: thr_wsc_o is 0 (short-to-battery level) while pwm_on_i is high and 1 (weak-short level) while it is low.
- R10: A shunt trip that occurs while pwm_on_i is high copies the one-hot low-side gate state ls_gate_i into bits 20:18. A shunt trip that occurs while pwm_on_i is low sets bit 17 (weak short). Either result is latched on the same edge that turns the bridge off.
- R11: A latched bit stays set until a clear command. The clear command takes effect only while the bridge is off and the settling time has ended, and it empties the register on the next edge. A start request is ignored while any bit is set.
- R12: A clear command given while an off-state failure is still present empties the register for one cycle only: the failure is latched again on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| off_bat_i | input | 3 | Off-state above-battery-threshold flags, bit 0=U, 1=V, 2=W |
| off_gnd_i | input | 3 | Off-state below-ground-threshold flags |
| on_bat_i | input | 3 | On-state short-to-battery flags (low-side switch drop) |
| on_gnd_i | input | 3 | On-state short-to-ground flags (high-side switch drop) |
| shunt_trip_i | input | 1 | Shunt comparator output |
| pwm_on_i | input | 1 | High during the PWM conduction phase |
| ls_gate_i | input | 3 | One-hot active low-side switch |
| start_req_i | input | 1 | Bridge start request |
| clr_cmd_i | input | 1 | Read-and-clear command for the failure register |
| bridge_en_o | output | 1 | Bridge enable; low turns all six switches off |
| off_mon_en_o | output | 1 | Off-state monitor enable |
| on_mon_en_o | output | 1 | On-state monitor enable |
| thr_wsc_o | output | 1 | Shunt threshold select, 1 selects the weak-short level |
| fault_o | output | 23 | Latched failure register |

## Verification
The timing of each result is fixed, so the bench samples on the exact cycle it is due.
- An off-state failure is latched FILT_LEN+3 edges after it reaches the pins.
- An on-state fault turns the bridge off FILT_LEN+3 edges after its flag reaches the pins.
- A combined diagnosis follows SETTLE_LEN+1 edges after the bridge turns off.
- A shunt result appears on the same edge that turns the bridge off.
- A start request or a clear command acts on the next edge.
- A failure that persists through a clear is latched again one edge after the clear.

The bench drives inputs on falling edges and counts rising edges with a single tick task. It checks each result one edge before it is due, expecting it absent, and again on the edge it lands, expecting it present.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
  localparam int NPH = 3;
  localparam int FW  = 23;

  // failure register layout
  localparam int B_BAT_AT  = 0;   // located short to battery, 3 bits
  localparam int B_GND_AT  = 3;   // located short to ground, 3 bits
  localparam int B_OPEN    = 6;   // open load per phase, 3 bits
  localparam int B_LOAD    = 9;   // load short per phase, 3 bits
  localparam int B_PAIR    = 12;  // phase-to-phase U-V, V-W, W-U
  localparam int B_BAT_ANY = 15;
  localparam int B_GND_ANY = 16;
  localparam int B_WEAK    = 17;
  localparam int B_SHUNT   = 18;  // shunt short to battery, 3 bits
  localparam int B_OFF_ODD = 21;
  localparam int B_ON_ODD  = 22;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_RUN    = 2'd1,
    ST_SETTLE = 2'd2
  } seq_st_e;
endpackage

// File: rtl/mfd_flag_cond.sv
module mfd_flag_cond #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      q_o <= 1'b0;
      cnt <= '0;
    end else begin
      s1 <= d_i;
      s2 <= s1;
      if (s2 == q_o) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        q_o <= s2;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mfd_decode.sv
module mfd_decode
  import mfd_pkg::*;
(
  input  logic [NPH-1:0] off_bat_i,
  input  logic [NPH-1:0] off_gnd_i,
  input  logic [NPH-1:0] on_bat_i,
  input  logic [NPH-1:0] on_gnd_i,
  output logic [FW-1:0]  off_bits_o,
  output logic [FW-1:0]  comb_bits_o
);
  logic           off_none, all_b, all_g;
  logic [2:0]     nb, ng;
  logic [NPH-1:0] pair;

  always_comb begin
    off_none = (off_bat_i == '0) && (off_gnd_i == '0);
    all_b    = (off_bat_i == '1) && (off_gnd_i == '0);
    all_g    = (off_bat_i == '0) && (off_gnd_i == '1);

    off_bits_o = '0;
    if (all_b)                                         off_bits_o[B_BAT_ANY] = 1'b1;
    else if (all_g)                                    off_bits_o[B_GND_ANY] = 1'b1;
    else if (off_bat_i == 3'b110 && off_gnd_i == 3'b001) off_bits_o[B_OPEN]   = 1'b1;
    else if (off_bat_i == 3'b010 && off_gnd_i == 3'b101) off_bits_o[B_OPEN+1] = 1'b1;
    else if (off_bat_i == 3'b011 && off_gnd_i == 3'b100) off_bits_o[B_OPEN+2] = 1'b1;
    else if (!off_none)                                off_bits_o[B_OFF_ODD] = 1'b1;

    nb   = 3'($countones(on_bat_i));
    ng   = 3'($countones(on_gnd_i));
    pair = on_bat_i | on_gnd_i;

    comb_bits_o = '0;
    if (all_b && nb == 3'd1 && ng == 3'd0) begin
      comb_bits_o[B_BAT_AT +: NPH] = on_bat_i;
    end else if (all_g && ng == 3'd1 && nb == 3'd0) begin
      comb_bits_o[B_GND_AT +: NPH] = on_gnd_i;
    end else if (off_none && (nb + ng) == 3'd1) begin
      comb_bits_o[B_LOAD +: NPH] = pair;
    end else if (off_none && nb == 3'd1 && ng == 3'd1 && (on_bat_i & on_gnd_i) == '0) begin
      case (pair)
        3'b011:  comb_bits_o[B_PAIR]   = 1'b1;
        3'b110:  comb_bits_o[B_PAIR+1] = 1'b1;
        default: comb_bits_o[B_PAIR+2] = 1'b1;
      endcase
    end else begin
      comb_bits_o = off_bits_o;
      if ((nb + ng) != 3'd0) comb_bits_o[B_ON_ODD] = 1'b1;
    end
  end
endmodule

// File: rtl/mfd_seq.sv
module mfd_seq
  import mfd_pkg::*;
#(
  parameter int FILT_LEN   = 3,
  parameter int SETTLE_LEN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    off_bat_i,
  input  logic [2:0]    off_gnd_i,
  input  logic [2:0]    on_bat_i,
  input  logic [2:0]    on_gnd_i,
  input  logic          shunt_trip_i,
  input  logic          pwm_on_i,
  input  logic [2:0]    ls_gate_i,
  input  logic          start_req_i,
  input  logic          clr_cmd_i,
  output logic          bridge_en_o,
  output logic          off_mon_en_o,
  output logic          on_mon_en_o,
  output logic          thr_wsc_o,
  output logic [22:0]   fault_o
);
  localparam int NFLAG = 4 * NPH + 1;
  localparam int SW    = $clog2(SETTLE_LEN + 1);

  logic [NFLAG-1:0] raw, filt;
  logic [NPH-1:0]   f_off_bat, f_off_gnd, f_on_bat, f_on_gnd;
  logic             f_shunt;
  logic [NPH-1:0]   hold_bat, hold_gnd;
  logic [FW-1:0]    off_bits, comb_bits, shunt_bits, set_bits, fault_q;
  logic [SW-1:0]    settle_cnt;
  logic             settled, on_fault, st_is_off;
  seq_st_e          st, st_nx;

  assign raw = {shunt_trip_i, on_gnd_i, on_bat_i, off_gnd_i, off_bat_i};

  for (genvar g = 0; g < NFLAG; g++) begin : g_cond
    mfd_flag_cond #(.FILT_LEN(FILT_LEN)) u_cond (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (raw[g]),
      .q_o  (filt[g])
    );
  end

  assign f_off_bat = filt[0 +: NPH];
  assign f_off_gnd = filt[NPH +: NPH];
  assign f_on_bat  = filt[2*NPH +: NPH];
  assign f_on_gnd  = filt[3*NPH +: NPH];
  assign f_shunt   = filt[4*NPH];

  mfd_decode u_dec (
    .off_bat_i  (f_off_bat),
    .off_gnd_i  (f_off_gnd),
    .on_bat_i   (hold_bat),
    .on_gnd_i   (hold_gnd),
    .off_bits_o (off_bits),
    .comb_bits_o(comb_bits)
  );

  assign settled   = (settle_cnt == SW'(SETTLE_LEN));
  assign on_fault  = (|f_on_bat) | (|f_on_gnd) | f_shunt;
  assign st_is_off = (st == ST_OFF);

  always_comb begin
    shunt_bits = '0;
    if (f_shunt) begin
      if (pwm_on_i) shunt_bits[B_SHUNT +: NPH] = ls_gate_i;
      else          shunt_bits[B_WEAK]         = 1'b1;
    end
  end

  always_comb begin
    set_bits = '0;
    case (st)
      ST_RUN:    if (on_fault) set_bits = shunt_bits;
      ST_SETTLE: if (settled)  set_bits = comb_bits;
      default:   if (settled && fault_q == '0) set_bits = off_bits;
    endcase
  end

  always_comb begin
    st_nx = st;
    case (st)
      ST_OFF:    if (start_req_i && settled && fault_q == '0 && off_bits == '0 && !clr_cmd_i)
                   st_nx = ST_RUN;
      ST_RUN:    if (on_fault) st_nx = ST_SETTLE;
      ST_SETTLE: if (settled)  st_nx = ST_OFF;
      default:   st_nx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_OFF;
      settle_cnt <= '0;
      fault_q    <= '0;
      hold_bat   <= '0;
      hold_gnd   <= '0;
    end else begin
      st <= st_nx;
      if (st == ST_RUN)  settle_cnt <= '0;
      else if (!settled) settle_cnt <= settle_cnt + 1'b1;
      if (st == ST_RUN && on_fault) begin
        hold_bat <= f_on_bat;
        hold_gnd <= f_on_gnd;
      end
      if (st_is_off && settled && clr_cmd_i) fault_q <= '0;
      else                                   fault_q <= fault_q | set_bits;
    end
  end

  assign bridge_en_o  = (st == ST_RUN);
  assign on_mon_en_o  = (st == ST_RUN);
  assign off_mon_en_o = (st != ST_RUN);
  assign thr_wsc_o    = ~pwm_on_i;
  assign fault_o      = fault_q;
endmodule

// File: rtl/mfd_seq_chk.sv
module mfd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bridge_en,
  input logic        clr_cmd,
  input logic        st_off,
  input logic [22:0] fault
);
  // R2: the bridge only turns on from the off state with an empty register
  assert_start_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bridge_en) |-> ($past(fault) == '0 && $past(st_off)));

  // R11: a set failure bit and a running bridge never coexist
  assert_fault_blocks_bridge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault != '0) |-> !bridge_en);

  // R11: bits only drop through a clear command
  assert_bits_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cmd |=> ((fault & $past(fault)) == $past(fault)));

  // R12: a clear while off empties the register for the next cycle
  assert_clear_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && st_off && !bridge_en && $past(st_off)) |=> (fault == '0 || $past(fault) == '0));
endmodule

bind mfd_seq mfd_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bridge_en(bridge_en_o),
  .clr_cmd  (clr_cmd_i),
  .st_off   (st_is_off),
  .fault    (fault_o)
);

// File: tb/mfd_seq_tb.sv
module mfd_seq_tb_top;
  localparam int FL = 3;
  localparam int SL = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  off_bat, off_gnd, on_bat, on_gnd, ls_gate;
  logic        shunt, pwm_on, start_req, clr_cmd;
  logic        bridge_en, off_mon_en, on_mon_en, thr_wsc;
  logic [22:0] fault;
  int          checks = 0;
  int          failures = 0;

  always #5 clk = ~clk;

  mfd_seq #(.FILT_LEN(FL), .SETTLE_LEN(SL)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .off_bat_i(off_bat), .off_gnd_i(off_gnd),
    .on_bat_i(on_bat), .on_gnd_i(on_gnd),
    .shunt_trip_i(shunt), .pwm_on_i(pwm_on), .ls_gate_i(ls_gate),
    .start_req_i(start_req), .clr_cmd_i(clr_cmd),
    .bridge_en_o(bridge_en), .off_mon_en_o(off_mon_en), .on_mon_en_o(on_mon_en),
    .thr_wsc_o(thr_wsc), .fault_o(fault)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {off_bat, off_gnd, on_bat, on_gnd, ls_gate} = '0;
    {shunt, start_req, clr_cmd} = '0;
    pwm_on = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(20);
  endtask

  task automatic start_bridge(input string req, input logic exp);
    start_req = 1'b1;
    tick(1);
    start_req = 1'b0;
    chk(req, bridge_en, exp);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    {off_bat, off_gnd, on_bat, on_gnd, ls_gate} = '0;
    {shunt, start_req, clr_cmd} = '0;
    pwm_on = 1'b1;
    tick(2);
    chk("R2 reset bridge", bridge_en, 0);
    chk("R2 reset offmon", off_mon_en, 1);
    chk("R2 reset fault", fault, 0);
    rst_n = 1'b1;
    start_req = 1'b1;   // too early: off monitor not settled
    tick(1);
    start_req = 1'b0;
    tick(1);
    chk("R2 early start ignored", bridge_en, 0);
    tick(20);
    start_bridge("R2 start accepted", 1);
    chk("R2 on monitor", on_mon_en, 1);
    chk("R2 off monitor stopped", off_mon_en, 0);
  endtask

  task automatic t_filter();
    do_reset();
    off_bat = 3'b111;
    tick(FL - 1);
    off_bat = 3'b000;
    tick(20);
    chk("R1 short pulse ignored", fault, 0);
    off_bat = 3'b111;
    tick(FL + 2);
    chk("R1 not yet latched", fault, 0);
    tick(1);
    chk("R1 latched on time", fault, 32'h1 << 15);
  endtask

  task automatic t_off_pattern(input logic [2:0] b, input logic [2:0] g, input int bit_i);
    do_reset();
    off_bat = b;
    off_gnd = g;
    tick(FL + 3);
    chk("R4 off decode", fault, 32'h1 << bit_i);
    start_bridge("R3 start blocked", 0);
  endtask

  // on-state fault with the given off pattern, checks R5 timing
  task automatic run_fault(input logic [2:0] b_on, input logic [2:0] g_on,
                           input logic [2:0] b_off, input logic [2:0] g_off);
    do_reset();
    start_bridge("R2 start", 1);
    on_bat  = b_on;
    on_gnd  = g_on;
    off_bat = b_off;
    off_gnd = g_off;
    tick(FL + 2);
    chk("R5 bridge still on", bridge_en, 1);
    tick(1);
    chk("R5 bridge off", bridge_en, 0);
    chk("R5 off monitor restarted", off_mon_en, 1);
    tick(SL);
    chk("R5 diagnosis not yet due", fault, 0);
    tick(1);
  endtask

  task automatic t_located();
    run_fault(3'b010, 3'b000, 3'b111, 3'b000);
    chk("R6 battery at V", fault, 32'h1 << 1);
    run_fault(3'b000, 3'b100, 3'b000, 3'b111);
    chk("R6 ground at W", fault, 32'h1 << 5);
  endtask

  task automatic t_load_short();
    run_fault(3'b000, 3'b001, 3'b000, 3'b000);
    chk("R7 load short U", fault, 32'h1 << 9);
    run_fault(3'b100, 3'b000, 3'b000, 3'b000);
    chk("R7 load short W", fault, 32'h1 << 11);
  endtask

  task automatic t_pair();
    run_fault(3'b010, 3'b001, 3'b000, 3'b000);
    chk("R8 U-V order a", fault, 32'h1 << 12);
    run_fault(3'b001, 3'b010, 3'b000, 3'b000);
    chk("R8 U-V order b", fault, 32'h1 << 12);
    run_fault(3'b100, 3'b010, 3'b000, 3'b000);
    chk("R8 V-W", fault, 32'h1 << 13);
  endtask

  task automatic t_thr();
    do_reset();
    pwm_on = 1'b1;
    tick(1);
    chk("R9 battery level", thr_wsc, 0);
    pwm_on = 1'b0;
    tick(1);
    chk("R9 weak level", thr_wsc, 1);
  endtask

  task automatic t_shunt(input logic pwm, input logic [2:0] ls, input int bit_i);
    do_reset();
    start_bridge("R2 start", 1);
    pwm_on  = pwm;
    ls_gate = ls;
    shunt   = 1'b1;
    tick(FL + 3);
    chk("R10 shunt bridge off", bridge_en, 0);
    chk("R10 shunt class", fault, 32'h1 << bit_i);
    tick(SL + 4);
    chk("R10 shunt final", fault, 32'h1 << bit_i);
  endtask

  task automatic t_clear();
    run_fault(3'b000, 3'b001, 3'b000, 3'b000);
    on_gnd = '0;
    tick(10);
    chk("R11 held", fault, 32'h1 << 9);
    start_bridge("R11 start blocked", 0);
    clr_cmd = 1'b1;
    tick(1);
    clr_cmd = 1'b0;
    chk("R11 cleared", fault, 0);
    start_bridge("R11 restart", 1);
  endtask

  task automatic t_relatch();
    do_reset();
    off_gnd = 3'b111;
    tick(10);
    chk("R12 latched", fault, 32'h1 << 16);
    clr_cmd = 1'b1;
    tick(1);
    clr_cmd = 1'b0;
    chk("R12 cleared", fault, 0);
    tick(1);
    chk("R12 relatched", fault, 32'h1 << 16);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset_state();
    t_filter();
    t_off_pattern(3'b111, 3'b000, 15);
    t_off_pattern(3'b000, 3'b111, 16);
    t_off_pattern(3'b110, 3'b001, 6);
    t_off_pattern(3'b010, 3'b101, 7);
    t_off_pattern(3'b011, 3'b100, 8);
    t_off_pattern(3'b001, 3'b000, 21);
    t_located();
    t_load_short();
    t_pair();
    t_thr();
    t_shunt(1'b1, 3'b010, 19);
    t_shunt(1'b0, 3'b001, 17);
    t_clear();
    t_relatch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule